// File: doc/BRIEF.md
# Logic Analyzer Command Receiver

This block sits between a UART receiver and a 32-channel capture engine. It takes the host's byte stream, one byte per `rx_valid` cycle, and decodes it into configuration register writes and control strobes. Commands come in two lengths:

- A short command is a single opcode byte with bit 7 clear.
- A long command is an opcode with bit 7 set, followed by four argument bytes that form a 32-bit word.

A zero byte seen between commands acts as a reset. A long command always consumes exactly four argument bytes, whatever their values. Because of this, a run of five zero bytes always brings the parser back to byte alignment. The host uses that run before any other traffic.

The block also answers the identify request. It pushes a fixed four-byte signature into a transmit byte interface with a valid/ready handshake. The register file holds the following, all visible to the capture engine:

- the sample clock divider;
- the capture size word;
- the flag byte;
- a mask, a value and a config word for each trigger stage.

Top module: `la_cmd_rx`

## Requirements
- R1: After reset, every configuration output is zero, and `run_pulse`, `reset_pulse`, `cfg_wr` and `tx_valid` are low.
- R2: Byte 0x00 received between commands raises `reset_pulse` for one cycle. It also cancels any signature transmission still in progress.
- R3: Five consecutive 0x00 bytes leave the parser idle and aligned, whether it started idle or 1 to 4 bytes into a long command. The next command is then decoded correctly.
- R4: Byte 0x01 received between commands raises `run_pulse` for one cycle.
- R5: Byte 0x02 received between commands makes the block send exactly four bytes: 0x31, 0x53, 0x4C, 0x4F, in that order. Each byte is held stable on `tx_data` with `tx_valid` high until `tx_ready` accepts it.
- R6: The metadata request 0x04, and every other short opcode (bit 7 clear) except 0x00, 0x01 and 0x02, produces no reply, no pulse and no register change.
- R7: An opcode with bit 7 set is followed by four argument bytes. The first of these lands in bits [7:0] of the argument and the last in bits [31:24]. `cfg_wr` pulses for one cycle after the fifth byte.
- R8: Opcode 0x80 loads the full 32-bit argument into `divider`. Opcode 0x81 loads it into `capture_size`.
- R9: Opcode 0x82 loads argument bits [7:0] into `flags`.
- R10: For stage s (0..3), opcode 0xC0+4s loads that stage's mask, 0xC1+4s loads its value, and 0xC2+4s loads its config. Each stage occupies bits [32s+31:32s] of its output.
- R11: A long opcode with no register assigned still consumes four argument bytes and changes no register.
- R12: Input bytes are taken only in cycles with `rx_valid` high. `rx_data` in any other cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the current byte |
| tx_valid | output | 1 | Signature byte offered |
| tx_data | output | 8 | Signature byte |
| run_pulse | output | 1 | Start-acquisition strobe |
| reset_pulse | output | 1 | Reset strobe toward the capture engine |
| cfg_wr | output | 1 | A long command has completed |
| divider | output | 32 | Sample clock divider |
| capture_size | output | 32 | Capture size word |
| flags | output | 8 | Flag byte |
| trig_mask | output | 128 | Trigger masks, stage s in bits [32s+31:32s] |
| trig_value | output | 128 | Trigger values, stage s in bits [32s+31:32s] |
| trig_cfg | output | 128 | Trigger configs, stage s in bits [32s+31:32s] |

## Verification
When a byte is accepted on a clock edge, `run_pulse`, `reset_pulse` and `cfg_wr` are high in the cycle that follows that edge. The register outputs and the first signature byte appear one cycle later still. A cancelled signature also drops `tx_valid` one cycle after `reset_pulse`. The bench drives each byte at a falling edge and samples at falling edges. It checks every strobe at the first falling edge after the accepting edge and every register and `tx_valid` at the second. The stimulus sweeps all 256 opcodes and puts the parser out of alignment at every possible offset before each realignment run.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_RESET     = 8'h00;
  localparam logic [7:0] OP_RUN       = 8'h01;
  localparam logic [7:0] OP_IDENT     = 8'h02;
  localparam logic [7:0] OP_META      = 8'h04;
  localparam logic [7:0] OP_DIVIDER   = 8'h80;
  localparam logic [7:0] OP_SIZE      = 8'h81;
  localparam logic [7:0] OP_FLAGS     = 8'h82;
  localparam logic [7:0] OP_TRIG_BASE = 8'hC0;
  localparam int         SIG_LEN      = 4;

  typedef enum logic {PS_IDLE, PS_ARG} parse_state_t;

  function automatic logic [7:0] sig_byte(input int idx);
    case (idx)
      0:       sig_byte = 8'h31;
      1:       sig_byte = 8'h53;
      2:       sig_byte = 8'h4C;
      default: sig_byte = 8'h4F;
    endcase
  endfunction
endpackage

// File: rtl/la_cmd_parser.sv
module la_cmd_parser
  import la_cmd_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ARG_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [BYTE_W-1:0]           in_byte,
  output logic                        run_p,
  output logic                        reset_p,
  output logic                        ident_p,
  output logic                        wr_p,
  output logic [BYTE_W-1:0]           wr_op,
  output logic [ARG_BYTES*BYTE_W-1:0] wr_arg
);
  localparam int ARG_W = ARG_BYTES * BYTE_W;
  localparam int CNT_W = (ARG_BYTES > 1) ? $clog2(ARG_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ARG_BYTES - 1);

  parse_state_t     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] op_q;
  logic [ARG_W-1:0]  arg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      arg_q   <= '0;
      run_p   <= 1'b0;
      reset_p <= 1'b0;
      ident_p <= 1'b0;
      wr_p    <= 1'b0;
    end else begin
      run_p   <= 1'b0;
      reset_p <= 1'b0;
      ident_p <= 1'b0;
      wr_p    <= 1'b0;
      if (in_valid) begin
        case (state_q)
          PS_IDLE: begin
            if (in_byte[BYTE_W-1]) begin
              op_q    <= in_byte;
              cnt_q   <= '0;
              state_q <= PS_ARG;
            end else begin
              reset_p <= (in_byte == BYTE_W'(OP_RESET));
              run_p   <= (in_byte == BYTE_W'(OP_RUN));
              ident_p <= (in_byte == BYTE_W'(OP_IDENT));
            end
          end
          default: begin
            arg_q[int'(cnt_q)*BYTE_W +: BYTE_W] <= in_byte;
            if (cnt_q == LAST_IDX) begin
              wr_p    <= 1'b1;
              cnt_q   <= '0;
              state_q <= PS_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign wr_op  = op_q;
  assign wr_arg = arg_q;

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({run_p, reset_p, ident_p, wr_p}));
  a_r12_strobe_needs_byte: assert property (@(posedge clk) disable iff (rst)
    (run_p || reset_p || ident_p || wr_p) |-> $past(in_valid));
  a_r7_write_ends_arg: assert property (@(posedge clk) disable iff (rst)
    wr_p |-> state_q == PS_IDLE && $past(state_q == PS_ARG));
endmodule

// File: rtl/la_cfg_regs.sv
module la_cfg_regs
  import la_cmd_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int ARG_W      = 32,
  parameter int FLAG_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_p,
  input  logic [7:0]                  wr_op,
  input  logic [ARG_W-1:0]            wr_arg,
  output logic [ARG_W-1:0]            divider_o,
  output logic [ARG_W-1:0]            size_o,
  output logic [FLAG_W-1:0]           flags_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_mask_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_value_o,
  output logic [NUM_STAGES*ARG_W-1:0] trig_cfg_o
);
  localparam int TRIG_SPAN = 4 * NUM_STAGES;

  logic [ARG_W-1:0]  div_q, size_q;
  logic [FLAG_W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      size_q  <= '0;
      flags_q <= '0;
    end else if (wr_p) begin
      if (wr_op == OP_DIVIDER) div_q   <= wr_arg;
      if (wr_op == OP_SIZE)    size_q  <= wr_arg;
      if (wr_op == OP_FLAGS)   flags_q <= wr_arg[FLAG_W-1:0];
    end
  end

  assign divider_o = div_q;
  assign size_o    = size_q;
  assign flags_o   = flags_q;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam logic [7:0] BASE = OP_TRIG_BASE + 8'(4 * s);
    logic [ARG_W-1:0] mask_q, value_q, cfg_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q  <= '0;
        value_q <= '0;
        cfg_q   <= '0;
      end else if (wr_p) begin
        if (wr_op == BASE)        mask_q  <= wr_arg;
        if (wr_op == BASE + 8'd1) value_q <= wr_arg;
        if (wr_op == BASE + 8'd2) cfg_q   <= wr_arg;
      end
    end

    assign trig_mask_o[s*ARG_W +: ARG_W]  = mask_q;
    assign trig_value_o[s*ARG_W +: ARG_W] = value_q;
    assign trig_cfg_o[s*ARG_W +: ARG_W]   = cfg_q;
  end

  function automatic logic op_known(input logic [7:0] op);
    int rel;
    rel = int'(op) - int'(OP_TRIG_BASE);
    op_known = (op == OP_DIVIDER) || (op == OP_SIZE) || (op == OP_FLAGS) ||
               (rel >= 0 && rel < TRIG_SPAN && op[1:0] != 2'b11);
  endfunction

  a_r11_unknown_no_change: assert property (@(posedge clk) disable iff (rst)
    (wr_p && !op_known(wr_op)) |=>
      $stable(div_q) && $stable(size_q) && $stable(flags_q) &&
      $stable(trig_mask_o) && $stable(trig_value_o) && $stable(trig_cfg_o));
  a_r8_divider_load: assert property (@(posedge clk) disable iff (rst)
    (wr_p && wr_op == OP_DIVIDER) |=> div_q == $past(wr_arg));
  a_r9_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_p |=> $stable(flags_q) && $stable(div_q) && $stable(size_q));
endmodule

// File: rtl/la_id_tx.sv
module la_id_tx
  import la_cmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              abort_p,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int IDX_W = $clog2(SIG_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SIG_LEN - 1);

  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (abort_p) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (!valid_q) begin
      if (start_p) begin
        valid_q <= 1'b1;
        idx_q   <= '0;
        data_q  <= BYTE_W'(sig_byte(0));
      end
    end else if (tx_ready) begin
      if (idx_q == LAST_IDX) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        data_q <= BYTE_W'(sig_byte(int'(idx_q) + 1));
      end
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;

  a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !abort_p) |=> tx_valid && $stable(tx_data));
  a_r5_first_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_data == BYTE_W'(8'h31));
  a_r2_abort_drops: assert property (@(posedge clk) disable iff (rst)
    abort_p |=> !tx_valid);
endmodule

// File: rtl/la_cmd_rx.sv
module la_cmd_rx
  import la_cmd_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int ARG_BYTES  = 4,
  parameter int FLAG_W     = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rx_valid,
  input  logic [7:0]                          rx_data,
  input  logic                                tx_ready,
  output logic                                tx_valid,
  output logic [7:0]                          tx_data,
  output logic                                run_pulse,
  output logic                                reset_pulse,
  output logic                                cfg_wr,
  output logic [ARG_BYTES*8-1:0]              divider,
  output logic [ARG_BYTES*8-1:0]              capture_size,
  output logic [FLAG_W-1:0]                   flags,
  output logic [NUM_STAGES*ARG_BYTES*8-1:0]   trig_mask,
  output logic [NUM_STAGES*ARG_BYTES*8-1:0]   trig_value,
  output logic [NUM_STAGES*ARG_BYTES*8-1:0]   trig_cfg
);
  localparam int ARG_W = ARG_BYTES * 8;

  logic             ident_p;
  logic [7:0]       wr_op;
  logic [ARG_W-1:0] wr_arg;

  la_cmd_parser #(.BYTE_W(8), .ARG_BYTES(ARG_BYTES)) u_parser (
    .clk     (clk),
    .rst     (rst),
    .in_valid(rx_valid),
    .in_byte (rx_data),
    .run_p   (run_pulse),
    .reset_p (reset_pulse),
    .ident_p (ident_p),
    .wr_p    (cfg_wr),
    .wr_op   (wr_op),
    .wr_arg  (wr_arg)
  );

  la_cfg_regs #(.NUM_STAGES(NUM_STAGES), .ARG_W(ARG_W), .FLAG_W(FLAG_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_p        (cfg_wr),
    .wr_op       (wr_op),
    .wr_arg      (wr_arg),
    .divider_o   (divider),
    .size_o      (capture_size),
    .flags_o     (flags),
    .trig_mask_o (trig_mask),
    .trig_value_o(trig_value),
    .trig_cfg_o  (trig_cfg)
  );

  la_id_tx #(.BYTE_W(8)) u_idtx (
    .clk     (clk),
    .rst     (rst),
    .start_p (ident_p),
    .abort_p (reset_pulse),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_data (tx_data)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !run_pulse && !reset_pulse && !cfg_wr && !tx_valid);
endmodule

// File: tb/la_cmd_rx_tb.sv
module la_cmd_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_ready = 1'b0;
  logic tx_valid, run_pulse, reset_pulse, cfg_wr;
  logic [7:0] tx_data, flags;
  logic [31:0] divider, capture_size;
  logic [NS*32-1:0] trig_mask, trig_value, trig_cfg;

  int total = 0;
  int bad = 0;

  logic [31:0] m_div, m_size;
  logic [7:0]  m_flags;
  logic [31:0] m_mask [NS];
  logic [31:0] m_value[NS];
  logic [31:0] m_cfg  [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  la_cmd_rx u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .run_pulse(run_pulse), .reset_pulse(reset_pulse), .cfg_wr(cfg_wr),
    .divider(divider), .capture_size(capture_size), .flags(flags),
    .trig_mask(trig_mask), .trig_value(trig_value), .trig_cfg(trig_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'h01;
  endtask

  task automatic check_regs(input string req);
    chk({req, " divider"}, divider, m_div);
    chk({req, " capture_size"}, capture_size, m_size);
    chk({req, " flags"}, {24'h0, flags}, {24'h0, m_flags});
    for (int s = 0; s < NS; s++) begin
      chk({req, " trig_mask"}, trig_mask[s*32 +: 32], m_mask[s]);
      chk({req, " trig_value"}, trig_value[s*32 +: 32], m_value[s]);
      chk({req, " trig_cfg"}, trig_cfg[s*32 +: 32], m_cfg[s]);
    end
  endtask

  task automatic model_write(input logic [7:0] op, input logic [31:0] arg);
    int rel;
    rel = int'(op) - 'hC0;
    if (op == 8'h80) m_div = arg;
    else if (op == 8'h81) m_size = arg;
    else if (op == 8'h82) m_flags = arg[7:0];
    else if (rel >= 0 && rel < 4*NS) begin
      case (op[1:0])
        2'd0: m_mask[rel/4] = arg;
        2'd1: m_value[rel/4] = arg;
        2'd2: m_cfg[rel/4] = arg;
        default: ;
      endcase
    end
  endtask

  // Long command: R7 assembly, strobe, then register update one cycle later
  task automatic send_long(input logic [7:0] op, input logic [31:0] arg, input string req);
    send_byte(op);
    for (int i = 0; i < 4; i++) send_byte(arg[i*8 +: 8]);
    chk("R7 cfg_wr after fifth byte", {31'h0, cfg_wr}, 32'h1);
    model_write(op, arg);
    @(negedge clk);
    chk("R7 cfg_wr single cycle", {31'h0, cfg_wr}, 32'h0);
    check_regs(req);
  endtask

  // R5: signature drain with one stall cycle on the second byte
  task automatic drain_sig();
    logic [7:0] sig [4];
    sig[0] = 8'h31; sig[1] = 8'h53; sig[2] = 8'h4C; sig[3] = 8'h4F;
    for (int i = 0; i < 4; i++) begin
      chk("R5 tx_valid during signature", {31'h0, tx_valid}, 32'h1);
      chk("R5 signature byte", {24'h0, tx_data}, {24'h0, sig[i]});
      if (i == 1) begin
        @(negedge clk);
        chk("R5 byte held while stalled", {24'h0, tx_data}, {24'h0, sig[i]});
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    chk("R5 exactly four bytes", {31'h0, tx_valid}, 32'h0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_div = '0; m_size = '0; m_flags = '0;
    for (int s = 0; s < NS; s++) begin
      m_mask[s] = '0; m_value[s] = '0; m_cfg[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_regs("R1 reset");
    chk("R1 run_pulse", {31'h0, run_pulse}, 32'h0);
    chk("R1 reset_pulse", {31'h0, reset_pulse}, 32'h0);
    chk("R1 cfg_wr", {31'h0, cfg_wr}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);

    // R12: bytes without rx_valid have no effect
    rx_data = 8'h01;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R12 no run without rx_valid", {31'h0, run_pulse}, 32'h0);
    end
    rx_data = 8'h02;
    repeat (2) @(negedge clk);
    chk("R12 no identify without rx_valid", {31'h0, tx_valid}, 32'h0);

    // Sweep of every opcode
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if (o[7]) begin
        send_long(o, {o ^ 8'h3C, 8'hA5, ~o, o}, "R8 R9 R10 R11 long sweep");
      end else begin
        send_byte(o);
        chk("R4 run_pulse", {31'h0, run_pulse}, {31'h0, o == 8'h01});
        chk("R2 reset_pulse", {31'h0, reset_pulse}, {31'h0, o == 8'h00});
        @(negedge clk);
        chk("R4 run_pulse one cycle", {31'h0, run_pulse}, 32'h0);
        chk("R6 reply only for identify", {31'h0, tx_valid}, {31'h0, o == 8'h02});
        if (o == 8'h02) drain_sig();
        check_regs("R6 short opcode");
      end
    end

    // R2: reset byte cancels a signature in progress
    send_byte(8'h02);
    @(negedge clk);
    chk("R2 signature started", {31'h0, tx_valid}, 32'h1);
    send_byte(8'h00);
    chk("R2 reset_pulse", {31'h0, reset_pulse}, 32'h1);
    @(negedge clk);
    chk("R2 signature cancelled", {31'h0, tx_valid}, 32'h0);

    // R3: realignment from every offset inside a long command
    for (int k = 0; k <= 4; k++) begin
      logic [31:0] part;
      part = '0;
      if (k >= 1) send_byte(8'h80);
      for (int i = 0; i < k - 1; i++) begin
        send_byte(8'(8'h11 * (i + 1)));
        part[i*8 +: 8] = 8'(8'h11 * (i + 1));
      end
      for (int z = 0; z < 5; z++) send_byte(8'h00);
      chk("R3 last zero is a reset", {31'h0, reset_pulse}, 32'h1);
      if (k >= 1) m_div = part;
      send_long(8'h81, 32'hDEAD_0000 + 32'(k), "R3 aligned after zeros");
    end

    // R9: flags only keeps the low byte; R10 stage 3 config
    send_long(8'h82, 32'hFFFF_FF5A, "R9 flags low byte");
    send_long(8'hCE, 32'h1234_5678, "R10 stage 3 config");
    send_long(8'hC3, 32'hCAFE_F00D, "R11 unassigned trigger slot");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule